// File: doc/BRIEF.md
# Link Receive Sequence Checker

This block sits on the receive side of a point-to-point link, between the byte stream recovered from the wire and the layer that consumes whole packets. Every packet begins with a two-byte header holding a sequence number and ends with a 32-bit CRC. The block verifies both, keeps the number it expects next, passes good packets upward with the CRC removed, and raises a one-cycle acknowledge or negative-acknowledge request carrying a sequence number toward the local transmitter, which turns it into a link message.

Bytes of an arriving packet are written into a circular byte buffer as they come in and are released to the output only once the trailing CRC has been seen and found good and the sequence number matched, so a packet that fails is never partly delivered. A failed packet, and every later packet that does not carry the expected number, is thrown away. The first such failure produces one negative acknowledge naming the expected number; further failures stay silent until the expected packet arrives. A replayed copy of the packet just accepted is dropped and answered with an acknowledge of that number.

Top module: `link_rx_seqchk`

## Requirements
- R1: Packet format: byte 0 bits 3:0 hold sequence bits 11:8 (bits 7:4 ignored), byte 1 holds sequence bits 7:0, then zero or more payload bytes, then four CRC bytes, most significant byte first. The CRC uses polynomial 0x04C11DB7, initial value 0xFFFFFFFF, bits taken most significant first, no reflection and no final inversion, computed over header and payload. A packet with a good CRC whose number equals next_seq is accepted: next_seq increments and an acknowledge (rsp_nak=0) names that number.
- R2: A packet whose CRC does not match is dropped; when no negative acknowledge is outstanding, a negative acknowledge (rsp_nak=1) names the current next_seq, which does not change.
- R3: A packet with a good CRC whose number is neither next_seq nor next_seq-1 is dropped and handled as in R2.
- R4: After a negative acknowledge, further failing or out-of-order packets are dropped without any response until a packet is accepted; after that a new failure may raise a negative acknowledge again.
- R5: A packet with a good CRC numbered next_seq-1 (modulo 4096) is dropped, forwards nothing, leaves next_seq unchanged and raises an acknowledge naming that number.
- R6: An accepted packet is forwarded as its header and payload bytes in arrival order with the four CRC bytes removed, fwd_sop on the first byte and fwd_eop on the last; no byte of a dropped packet is ever forwarded.
- R7: Sequence numbers are 12 bits and wrap: after 4095 the expected number is 0, and a duplicate check across the wrap treats 0 as the predecessor of 1.
- R8: After reset next_seq is 0 and fwd_valid and rsp_valid are low.
- R9: A packet shorter than six bytes is a failure handled as in R2.
- R10: The response appears as a single-cycle pulse on the clock edge following the edge that samples the packet's end byte.
- R11: Packets arriving back to back with no idle cycle are each judged and forwarded correctly while earlier packets are still being forwarded.
- R12: A packet that does not fit in the free space of the 128-byte buffer is a failure handled as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Input byte present this cycle |
| rx_sop | input | 1 | Input byte is the first of a packet |
| rx_eop | input | 1 | Input byte is the last of a packet |
| rx_byte | input | 8 | Input byte |
| fwd_valid | output | 1 | Forwarded byte present |
| fwd_sop | output | 1 | Forwarded byte begins a packet |
| fwd_eop | output | 1 | Forwarded byte ends a packet |
| fwd_byte | output | 8 | Forwarded byte |
| rsp_valid | output | 1 | Acknowledge request pulse |
| rsp_nak | output | 1 | 1 = negative acknowledge, 0 = acknowledge |
| rsp_seq | output | 12 | Sequence number carried by the request |
| next_seq | output | 12 | Sequence number expected next |

## Verification
The two functions that share cycles are writing a newly arriving packet into the buffer and draining an earlier accepted packet out of it, together with the commit of a verdict on an end byte while the read side is busy. Back-to-back packets with no idle cycle, of different payload lengths including an empty payload, force both pointers to move in the same cycles. The forwarded stream, with its start and end markers, is compared byte for byte with the list the bench builds, and the response queue must hold exactly one acknowledge per packet in order.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        VERD_NONE,
        VERD_TAKE,
        VERD_DUP,
        VERD_BAD
    } verdict_e;

    localparam int HDR_BYTES = 2;
    localparam int CRC_BYTES = 4;
    localparam int MIN_BYTES = HDR_BYTES + CRC_BYTES;

    // one byte through a non-reflected CRC-32 shift register, MSB first
    function automatic logic [31:0] crc_byte(input logic [31:0] cur,
                                             input logic [7:0]  data,
                                             input logic [31:0] poly);
        logic [31:0] r;
        logic        fb;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ data[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/lrs_crc.sv
module lrs_crc #(
    parameter logic [31:0] POLY = 32'h04C1_1DB7,
    parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic        byte_first,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_after
);
    import lrs_pkg::*;

    logic [31:0] crc_d, crc_q;

    // running register including the present byte; the residue over
    // header, payload and CRC bytes is zero for an intact packet
    always_comb begin
        crc_after = crc_byte(byte_first ? INIT : crc_q, byte_in, POLY);
        crc_d     = byte_en ? crc_after : crc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/lrs_ctrl.sv
module lrs_ctrl #(
    parameter int SEQ_W = 12,
    parameter int LEN_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [7:0]            in_data,
    input  logic [31:0]           crc_after,
    input  logic                  ovr,
    output logic                  beat,
    output lrs_pkg::verdict_e     verdict,
    output logic [LEN_W-1:0]      pkt_len,
    output logic                  ack_valid,
    output logic                  ack_nak,
    output logic [SEQ_W-1:0]      ack_seq,
    output logic [SEQ_W-1:0]      exp_seq
);
    import lrs_pkg::*;

    localparam logic [LEN_W-1:0] LEN_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BYTES);
    localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);

    typedef struct packed {
        logic             in_pkt;
        logic [LEN_W-1:0] cnt;
        logic [15:0]      hdr;
        logic [SEQ_W-1:0] exp;
        logic             nak_out;
        logic             rv;
        logic             rn;
        logic [SEQ_W-1:0] rs;
    } ctrl_t;

    ctrl_t q, d;

    logic [LEN_W-1:0] cur_cnt;
    logic [15:0]      hdr_base, hdr_n;
    logic [SEQ_W-1:0] seq;
    logic             crc_good;

    // a byte belongs to a packet when it opens one or one is open
    assign beat = in_valid && (in_sop || q.in_pkt);

    always_comb begin
        d        = q;
        d.rv     = 1'b0;
        verdict  = VERD_NONE;
        cur_cnt  = in_sop ? '0 : q.cnt;
        pkt_len  = (cur_cnt == LEN_MAX) ? cur_cnt : cur_cnt + 1'b1;
        hdr_base = in_sop ? 16'h0 : q.hdr;
        hdr_n    = (cur_cnt < HDR_LEN) ? {hdr_base[7:0], in_data} : hdr_base;
        seq      = hdr_n[SEQ_W-1:0];
        crc_good = (crc_after == 32'h0) && (pkt_len >= LEN_MIN) && !ovr;

        if (beat) begin
            d.in_pkt = !in_eop;
            d.cnt    = pkt_len;
            d.hdr    = hdr_n;
            if (in_eop) begin
                if (crc_good && seq == q.exp) begin
                    verdict   = VERD_TAKE;
                    d.exp     = q.exp + 1'b1;
                    d.nak_out = 1'b0;
                    d.rv      = 1'b1;
                    d.rn      = 1'b0;
                    d.rs      = seq;
                end else if (crc_good && seq == SEQ_W'(q.exp - 1'b1)) begin
                    verdict = VERD_DUP;
                    d.rv    = 1'b1;
                    d.rn    = 1'b0;
                    d.rs    = seq;
                end else begin
                    verdict = VERD_BAD;
                    if (!q.nak_out) begin
                        d.nak_out = 1'b1;
                        d.rv      = 1'b1;
                        d.rn      = 1'b1;
                        d.rs      = q.exp;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_valid = q.rv;
    assign ack_nak   = q.rn;
    assign ack_seq   = q.rs;
    assign exp_seq   = q.exp;

endmodule

// File: rtl/lrs_buf.sv
module lrs_buf #(
    parameter int AW    = 7,
    parameter int LEN_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_first,
    input  logic [7:0]            wr_data,
    input  lrs_pkg::verdict_e     verdict,
    input  logic [LEN_W-1:0]      pkt_len,
    output logic                  ovr,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic [7:0]            out_data
);
    import lrs_pkg::*;

    localparam int DEPTH = 1 << AW;
    typedef logic [AW:0] ptr_t;
    localparam ptr_t CAP = ptr_t'(DEPTH);

    typedef struct packed {
        ptr_t       wr;
        ptr_t       start;
        ptr_t       commit;
        ptr_t       rd;
        logic       ovr;
        logic       first;
        logic       ov;
        logic       osop;
        logic       oeop;
        logic [7:0] odata;
    } buf_t;

    buf_t q, d;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] lastm;

    ptr_t base, new_commit;
    logic full, do_write, set_last;

    assign base     = wr_first ? q.start : q.wr;
    assign full     = ptr_t'(base - q.rd) == CAP;
    assign do_write = wr_en && !full;
    assign ovr      = wr_en && (full || (!wr_first && q.ovr));

    always_comb begin
        d          = q;
        d.ov       = 1'b0;
        d.osop     = 1'b0;
        d.oeop     = 1'b0;
        set_last   = 1'b0;
        new_commit = q.start + ptr_t'(pkt_len - LEN_W'(CRC_BYTES));

        if (wr_en) d.ovr = ovr;
        if (do_write) d.wr = base + 1'b1;

        unique case (verdict)
            VERD_TAKE: begin
                d.commit = new_commit;
                d.start  = new_commit;
                d.wr     = new_commit;
                set_last = 1'b1;
            end
            VERD_DUP, VERD_BAD: d.wr = q.start;
            default: ;
        endcase

        // release one committed byte per cycle
        if (q.rd != q.commit) begin
            d.ov    = 1'b1;
            d.odata = mem[q.rd[AW-1:0]];
            d.oeop  = lastm[q.rd[AW-1:0]];
            d.osop  = q.first;
            d.first = lastm[q.rd[AW-1:0]];
            d.rd    = q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[base[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lastm <= '0;
        end else begin
            if (do_write) lastm[base[AW-1:0]] <= 1'b0;
            if (set_last) lastm[new_commit[AW-1:0] - 1'b1] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_sop   = q.osop;
    assign out_eop   = q.oeop;
    assign out_data  = q.odata;

endmodule

// File: rtl/link_rx_seqchk.sv
module link_rx_seqchk #(
    parameter int          SEQ_W    = 12,
    parameter int          BUF_AW   = 7,
    parameter logic [31:0] CRC_POLY = 32'h04C1_1DB7,
    parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic             rx_eop,
    input  logic [7:0]       rx_byte,
    output logic             fwd_valid,
    output logic             fwd_sop,
    output logic             fwd_eop,
    output logic [7:0]       fwd_byte,
    output logic             rsp_valid,
    output logic             rsp_nak,
    output logic [SEQ_W-1:0] rsp_seq,
    output logic [SEQ_W-1:0] next_seq
);
    import lrs_pkg::*;

    localparam int LEN_W = BUF_AW + 2;

    logic             beat;
    logic             ovr;
    logic [31:0]      crc_after;
    verdict_e         verdict;
    logic [LEN_W-1:0] pkt_len;

    lrs_crc #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) crc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_en    (beat),
        .byte_first (rx_sop),
        .byte_in    (rx_byte),
        .crc_after  (crc_after)
    );

    lrs_ctrl #(
        .SEQ_W (SEQ_W),
        .LEN_W (LEN_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_sop    (rx_sop),
        .in_eop    (rx_eop),
        .in_data   (rx_byte),
        .crc_after (crc_after),
        .ovr       (ovr),
        .beat      (beat),
        .verdict   (verdict),
        .pkt_len   (pkt_len),
        .ack_valid (rsp_valid),
        .ack_nak   (rsp_nak),
        .ack_seq   (rsp_seq),
        .exp_seq   (next_seq)
    );

    lrs_buf #(
        .AW    (BUF_AW),
        .LEN_W (LEN_W)
    ) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (beat),
        .wr_first  (rx_sop),
        .wr_data   (rx_byte),
        .verdict   (verdict),
        .pkt_len   (pkt_len),
        .ovr       (ovr),
        .out_valid (fwd_valid),
        .out_sop   (fwd_sop),
        .out_eop   (fwd_eop),
        .out_data  (fwd_byte)
    );

endmodule

// File: rtl/link_rx_seqchk_sva.sv
module link_rx_seqchk_sva #(
    parameter int SEQ_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_eop,
    input logic             fwd_valid,
    input logic             fwd_sop,
    input logic             fwd_eop,
    input logic             rsp_valid,
    input logic             rsp_nak,
    input logic [SEQ_W-1:0] rsp_seq,
    input logic [SEQ_W-1:0] next_seq
);
    localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

    logic nak_pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                nak_pend_q <= 1'b0;
        else if (rsp_valid && rsp_nak)             nak_pend_q <= 1'b1;
        else if (rsp_valid && rsp_seq == next_seq - ONE && !rsp_nak
                 && next_seq != $past(next_seq))   nak_pend_q <= 1'b0;
    end

    // R10
    rsp_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rx_valid && rx_eop));

    // R1
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(next_seq) |-> (rsp_valid && !rsp_nak &&
            rsp_seq == $past(next_seq) && next_seq == $past(next_seq) + ONE));

    // R2
    nak_names_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_nak) |-> (rsp_seq == next_seq && $stable(next_seq)));

    // R4
    single_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_nak) |-> !nak_pend_q);

    // R5
    ack_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_nak) |->
            (rsp_seq == $past(next_seq) || rsp_seq == $past(next_seq) - ONE));

    // R6
    marks_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sop || fwd_eop) |-> fwd_valid);

    // R6
    sop_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && $past(fwd_valid && fwd_eop)) |-> fwd_sop);

endmodule

bind link_rx_seqchk link_rx_seqchk_sva #(.SEQ_W(SEQ_W)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_eop    (rx_eop),
    .fwd_valid (fwd_valid),
    .fwd_sop   (fwd_sop),
    .fwd_eop   (fwd_eop),
    .rsp_valid (rsp_valid),
    .rsp_nak   (rsp_nak),
    .rsp_seq   (rsp_seq),
    .next_seq  (next_seq)
);

// File: tb/link_rx_seqchk_tb.sv
module link_rx_seqchk_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_byte = 8'h0;
    logic        fwd_valid, fwd_sop, fwd_eop;
    logic [7:0]  fwd_byte;
    logic        rsp_valid, rsp_nak;
    logic [11:0] rsp_seq, next_seq;

    int errors = 0;
    int checks = 0;

    logic [9:0]  fwd_q[$];
    logic [9:0]  exp_q[$];
    logic [12:0] rsp_q[$];

    always #10 clk = ~clk;

    link_rx_seqchk dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_byte(rx_byte),
        .fwd_valid(fwd_valid), .fwd_sop(fwd_sop), .fwd_eop(fwd_eop), .fwd_byte(fwd_byte),
        .rsp_valid(rsp_valid), .rsp_nak(rsp_nak), .rsp_seq(rsp_seq), .next_seq(next_seq)
    );

    always @(negedge clk) begin
        if (rsp_valid) rsp_q.push_back({rsp_nak, rsp_seq});
        if (fwd_valid) fwd_q.push_back({fwd_sop, fwd_eop, fwd_byte});
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (b[k]) begin
            for (int i = 7; i >= 0; i--) begin
                if (c[31] ^ b[k][i]) c = (c << 1) ^ 32'h04C1_1DB7;
                else                 c = c << 1;
            end
        end
        return c;
    endfunction

    task automatic idle(input int n);
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] b[$]);
        foreach (b[i]) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sop   = (i == 0);
            rx_eop   = (i == b.size() - 1);
            rx_byte  = b[i];
        end
    endtask

    // builds header, payload, CRC; optionally corrupts and records expected output
    task automatic send_pkt(input int seq, input int plen, input logic [7:0] seed,
                            input bit corrupt, input bit expect_fwd);
        logic [7:0]  b[$];
        logic [31:0] c;
        b.push_back({4'h0, 4'(seq >> 8)});
        b.push_back(8'(seq));
        for (int i = 0; i < plen; i++) b.push_back(seed + 8'(i));
        if (expect_fwd)
            foreach (b[i]) exp_q.push_back({(i == 0), (i == b.size() - 1), b[i]});
        c = ref_crc(b);
        b.push_back(c[31:24]); b.push_back(c[23:16]);
        b.push_back(c[15:8]);  b.push_back(c[7:0]);
        if (corrupt) b[b.size() - 1] = b[b.size() - 1] ^ 8'h01;
        send_raw(b);
    endtask

    task automatic expect_rsp(input bit nak, input int seq, input string req);
        check(rsp_q.size() == 1, {req, " response count"}, rsp_q.size(), 1);
        if (rsp_q.size() >= 1) begin
            check(rsp_q[0][12] == nak, {req, " response kind"}, rsp_q[0][12], nak);
            check(rsp_q[0][11:0] == 12'(seq), {req, " response seq"}, rsp_q[0][11:0], seq);
        end
        rsp_q.delete();
    endtask

    task automatic expect_silent(input string req);
        check(rsp_q.size() == 0, {req, " no response"}, rsp_q.size(), 0);
        rsp_q.delete();
    endtask

    task automatic check_fwd(input string req);
        check(fwd_q.size() == exp_q.size(), {req, " forwarded length"}, fwd_q.size(), exp_q.size());
        if (fwd_q.size() == exp_q.size())
            foreach (exp_q[i])
                check(fwd_q[i] == exp_q[i], {req, " forwarded byte"}, fwd_q[i], exp_q[i]);
        fwd_q.delete();
        exp_q.delete();
    endtask

    task automatic t_reset();
        check(next_seq == 12'd0, "R8 next_seq", next_seq, 0);
        check(!fwd_valid, "R8 fwd_valid", fwd_valid, 0);
        check(!rsp_valid, "R8 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_good();
        send_pkt(0, 4, 8'h10, 1'b0, 1'b1);
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
        check(rsp_valid && !rsp_nak, "R10 pulse after end", rsp_valid, 1);
        @(negedge clk);
        check(!rsp_valid, "R10 single cycle", rsp_valid, 0);
        idle(20);
        expect_rsp(1'b0, 0, "R1");
        check(next_seq == 12'd1, "R1 next_seq", next_seq, 1);
        check_fwd("R6");
    endtask

    task automatic t_errors();
        send_pkt(1, 5, 8'h30, 1'b1, 1'b0); idle(20);
        expect_rsp(1'b1, 1, "R2");
        check(next_seq == 12'd1, "R2 next_seq held", next_seq, 1);
        send_pkt(2, 3, 8'h40, 1'b0, 1'b0); idle(20);
        expect_silent("R4 after nak");
        send_pkt(1, 3, 8'h50, 1'b1, 1'b0); idle(20);
        expect_silent("R4 second crc error");
        check_fwd("R2 nothing forwarded");
        send_pkt(1, 2, 8'h60, 1'b0, 1'b1); idle(20);
        expect_rsp(1'b0, 1, "R4 recovery");
        check_fwd("R6 recovery");
        send_pkt(5, 2, 8'h70, 1'b0, 1'b0); idle(20);
        expect_rsp(1'b1, 2, "R3");
        check(next_seq == 12'd2, "R3 next_seq held", next_seq, 2);
        send_pkt(1, 2, 8'h80, 1'b0, 1'b0); idle(20);
        expect_rsp(1'b0, 1, "R5");
        check(next_seq == 12'd2, "R5 next_seq held", next_seq, 2);
        check_fwd("R5 nothing forwarded");
    endtask

    task automatic t_b2b();
        send_pkt(2, 3, 8'hA0, 1'b0, 1'b1);
        send_pkt(3, 0, 8'hB0, 1'b0, 1'b1);
        send_pkt(4, 7, 8'hC0, 1'b0, 1'b1);
        idle(40);
        check(rsp_q.size() == 3, "R11 response count", rsp_q.size(), 3);
        for (int i = 0; i < 3 && i < rsp_q.size(); i++)
            check(rsp_q[i] == {1'b0, 12'(2 + i)}, "R11 response", rsp_q[i], 2 + i);
        rsp_q.delete();
        check(next_seq == 12'd5, "R11 next_seq", next_seq, 5);
        check_fwd("R11");
    endtask

    task automatic t_short_ovr();
        logic [7:0] s[$];
        s.push_back(8'h00); s.push_back(8'h05); s.push_back(8'h99);
        send_raw(s); idle(20);
        expect_rsp(1'b1, 5, "R9");
        send_pkt(5, 1, 8'h11, 1'b0, 1'b1); idle(20);
        expect_rsp(1'b0, 5, "R9 recovery");
        send_pkt(6, 130, 8'h22, 1'b0, 1'b0); idle(20);
        expect_rsp(1'b1, 6, "R12");
        check(next_seq == 12'd6, "R12 next_seq held", next_seq, 6);
        send_pkt(6, 2, 8'h33, 1'b0, 1'b1); idle(20);
        expect_rsp(1'b0, 6, "R12 recovery");
        check_fwd("R12");
    endtask

    task automatic t_wrap();
        int n = 0;
        bit all_ack = 1'b1;
        for (int s = 7; s <= 4094; s++) begin
            send_pkt(s, 0, 8'(s), 1'b0, 1'b0);
            n++;
        end
        idle(20);
        foreach (rsp_q[i]) if (rsp_q[i][12]) all_ack = 1'b0;
        check(rsp_q.size() == n, "R7 run responses", rsp_q.size(), n);
        check(all_ack, "R7 run all acks", all_ack, 1);
        check(next_seq == 12'd4095, "R7 before wrap", next_seq, 4095);
        rsp_q.delete(); fwd_q.delete();
        send_pkt(4095, 1, 8'h44, 1'b0, 1'b1); idle(20);
        expect_rsp(1'b0, 4095, "R7 top value");
        check(next_seq == 12'd0, "R7 wrapped", next_seq, 0);
        send_pkt(0, 1, 8'h55, 1'b0, 1'b1); idle(20);
        expect_rsp(1'b0, 0, "R7 zero accepted");
        send_pkt(0, 1, 8'h66, 1'b0, 1'b0); idle(20);
        expect_rsp(1'b0, 0, "R7 duplicate across wrap");
        check(next_seq == 12'd1, "R7 next_seq", next_seq, 1);
        check_fwd("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_good();
        t_errors();
        t_b2b();
        t_short_ovr();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule